// File: doc/BRIEF.md
# Branch-history context filter

This block decides whether a conditional instruction prefetch should be issued. It keeps a compact signature of the 32 most recently executed basic-block addresses. Each new address is hashed to 16 bits and added to a bank of per-bit up/down counters. The hash of the address that leaves the window in the same cycle is subtracted. The live signature is the set of counters that are non-zero.

A prefetch request carries a 16-bit context hash, which was computed offline from the blocks known to lead to a miss. The request fires only when every set bit of that context is also set in the live signature. Otherwise it is suppressed. The decision comes back one cycle after the request, together with the request's tag.

The hash first XOR-folds the 64-bit address into 16 bits by combining bits 15:0, 31:16, 47:32 and 63:48. It then mixes the result in three steps, each truncated to 16 bits:
1. x ^= x << 5
2. x ^= x >> 7
3. x ^= x << 3

Top module: `ctx_filter`

## Requirements
- R1: After reset the signature is empty and `resp_valid_o` is 0. A query with context 0xFFFF is then answered with `resp_fire_o` = 0.
- R2: A query accepted at a clock edge is answered at the next edge. At that edge `resp_valid_o` = 1 and `resp_tag_o` equals the query's tag. `resp_valid_o` is 0 in any cycle that follows a cycle with no query.
- R3: `resp_fire_o` is 1 exactly when (context AND NOT signature) == 0. Signature bit i is 1 when counter i is non-zero.
- R4: A push adds 1 to counter i for every bit i that is set in the hash of the pushed address, using the hash defined above.
- R5: Once 32 entries are held, each push removes the hash of the oldest entry by subtracting 1 from counter i for every set bit i of that hash. The window therefore always covers exactly the last 32 pushes.
- R6: Until 32 entries have been pushed after reset, nothing is evicted and no counter is decremented.
- R7: A query in the same cycle as a push is decided on the signature from before that push.
- R8: A context of 0 always fires.
- R9: When a push and an eviction in the same cycle touch the same bit, that counter is left unchanged. Repeatedly pushing one address therefore keeps its bits present.
- R10: No counter ever exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | A block address enters the history |
| push_addr_i | input | 64 | Executed block address |
| query_valid_i | input | 1 | Conditional prefetch request |
| query_ctx_i | input | 16 | Context hash carried by the request |
| query_tag_i | input | 8 | Request tag, returned with the decision |
| resp_valid_o | output | 1 | Decision valid |
| resp_fire_o | output | 1 | 1 = issue the prefetch, 0 = suppress it |
| resp_tag_o | output | 8 | Tag of the request being answered |

## Verification
Counters and history update at the edge that accepts a push. A decision is registered at the edge that accepts its query, so it is due one cycle after the query. It is based on the counter values held just before that edge.

The bench drives inputs at the falling edge and samples the response 1 ns after the next rising edge. It computes the expected decision from its model signature as it stood before that cycle's push, and only then updates the model. Same-cycle push and query (R7), the fill boundary at 32 entries (R5, R6) and repeated identical pushes (R9) are run as directed cases. Mixed random traffic follows them.

// File: rtl/ctx_filter_pkg.sv
package ctx_filter_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned SIG_W  = 16;
  localparam int unsigned DEPTH  = 32;
  localparam int unsigned TAG_W  = 8;
  localparam int unsigned NCHUNK = ADDR_W / SIG_W;

  typedef logic [SIG_W-1:0] sig_t;

  // XOR fold followed by shift/xor mixing, no multiplier
  function automatic sig_t hash_addr(logic [ADDR_W-1:0] a);
    sig_t x;
    x = '0;
    for (int unsigned k = 0; k < NCHUNK; k++) x ^= a[k*SIG_W +: SIG_W];
    x = x ^ (x << 5);
    x = x ^ (x >> 7);
    x = x ^ (x << 3);
    return x;
  endfunction
endpackage

// File: rtl/ctx_hash.sv
module ctx_hash
  import ctx_filter_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output sig_t              hash_o
);
  assign hash_o = hash_addr(addr_i);
endmodule

// File: rtl/ctx_hist_fifo.sv
module ctx_hist_fifo
  import ctx_filter_pkg::*;
#(
  parameter int unsigned DEPTH_P = DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  sig_t hash_i,
  output logic evict_o,
  output sig_t old_hash_o
);
  localparam int unsigned PTR_W  = (DEPTH_P > 1) ? $clog2(DEPTH_P) : 1;
  localparam int unsigned FILL_W = $clog2(DEPTH_P + 1);
  localparam logic [PTR_W-1:0]  LAST_PTR = PTR_W'(DEPTH_P - 1);
  localparam logic [FILL_W-1:0] FULL_CNT = FILL_W'(DEPTH_P);

  sig_t              mem_q [DEPTH_P];
  logic [PTR_W-1:0]  wptr_q;
  logic [FILL_W-1:0] fill_q;
  logic              full;

  assign full       = (fill_q == FULL_CNT);
  assign evict_o    = push_i & full;
  // slot about to be overwritten holds the oldest entry once full
  assign old_hash_o = mem_q[wptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH_P); i++) mem_q[i] <= '0;
      wptr_q <= '0;
      fill_q <= '0;
    end else if (push_i) begin
      mem_q[wptr_q] <= hash_i;
      wptr_q        <= (wptr_q == LAST_PTR) ? '0 : wptr_q + 1'b1;
      if (!full) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctx_sig_counters.sv
module ctx_sig_counters
  import ctx_filter_pkg::*;
#(
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  sig_t                   inc_i,
  input  sig_t                   dec_i,
  output sig_t                   sig_o,
  output logic [SIG_W*CNT_W-1:0] cnt_o
);
  for (genvar i = 0; i < int'(SIG_W); i++) begin : g_bit
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cnt_q <= '0;
      else if (inc_i[i] && !dec_i[i]) cnt_q <= cnt_q + 1'b1;
      else if (dec_i[i] && !inc_i[i]) cnt_q <= cnt_q - 1'b1;
    end

    assign sig_o[i]                 = |cnt_q;
    assign cnt_o[i*CNT_W +: CNT_W]  = cnt_q;
  end
endmodule

// File: rtl/ctx_filter.sv
module ctx_filter
  import ctx_filter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_valid_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              query_valid_i,
  input  logic [SIG_W-1:0]  query_ctx_i,
  input  logic [TAG_W-1:0]  query_tag_i,
  output logic              resp_valid_o,
  output logic              resp_fire_o,
  output logic [TAG_W-1:0]  resp_tag_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  sig_t                   new_hash, old_hash, sig_w, inc_mask, dec_mask;
  logic                   evict;
  logic [SIG_W*CNT_W-1:0] cnt_flat;
  logic                   subset_ok;

  ctx_hash u_hash (
    .addr_i (push_addr_i),
    .hash_o (new_hash)
  );

  ctx_hist_fifo #(.DEPTH_P(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_valid_i),
    .hash_i     (new_hash),
    .evict_o    (evict),
    .old_hash_o (old_hash)
  );

  assign inc_mask = push_valid_i ? new_hash : '0;
  assign dec_mask = evict ? old_hash : '0;

  ctx_sig_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (inc_mask),
    .dec_i  (dec_mask),
    .sig_o  (sig_w),
    .cnt_o  (cnt_flat)
  );

  // subset test on pre-push signature
  assign subset_ok = ~|(query_ctx_i & ~sig_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_fire_o  <= 1'b0;
      resp_tag_o   <= '0;
    end else begin
      resp_valid_o <= query_valid_i;
      if (query_valid_i) begin
        resp_fire_o <= subset_ok;
        resp_tag_o  <= query_tag_i;
      end
    end
  end
endmodule

// File: rtl/ctx_filter_chk.sv
module ctx_filter_chk
  import ctx_filter_pkg::*;
#(
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   query_valid_i,
  input logic [SIG_W-1:0]       query_ctx_i,
  input logic [TAG_W-1:0]       query_tag_i,
  input logic                   resp_valid_o,
  input logic                   resp_fire_o,
  input logic [TAG_W-1:0]       resp_tag_o,
  input logic [SIG_W-1:0]       sig_w,
  input logic [SIG_W*CNT_W-1:0] cnt_flat
);
  // R2
  resp_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    query_valid_i |=> resp_valid_o);
  // R2
  resp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !query_valid_i |=> !resp_valid_o);
  // R2
  resp_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    query_valid_i |=> resp_tag_o == $past(query_tag_i));
  // R3
  subset_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_valid_i && ((query_ctx_i & sig_w) == query_ctx_i)) |=> resp_fire_o);
  // R3
  subset_supp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_valid_i && ((query_ctx_i & ~sig_w) != '0)) |=> !resp_fire_o);
  // R8
  zero_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_valid_i && query_ctx_i == '0) |=> resp_fire_o);

  for (genvar i = 0; i < int'(SIG_W); i++) begin : g_cnt
    // R10
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_flat[i*CNT_W +: CNT_W] <= CNT_W'(DEPTH));
  end
endmodule

bind ctx_filter ctx_filter_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .query_valid_i (query_valid_i),
  .query_ctx_i   (query_ctx_i),
  .query_tag_i   (query_tag_i),
  .resp_valid_o  (resp_valid_o),
  .resp_fire_o   (resp_fire_o),
  .resp_tag_o    (resp_tag_o),
  .sig_w         (sig_w),
  .cnt_flat      (cnt_flat)
);

// File: tb/ctx_filter_bench.sv
`timescale 1ns/1ps
module ctx_filter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_valid_i = 1'b0;
  logic [63:0] push_addr_i = '0;
  logic        query_valid_i = 1'b0;
  logic [15:0] query_ctx_i = '0;
  logic [7:0]  query_tag_i = '0;
  logic        resp_valid_o, resp_fire_o;
  logic [7:0]  resp_tag_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [15:0] hq[$];
  int          cntm[16];

  always #5 clk_i = ~clk_i;

  ctx_filter u_ctx_filter (.*);

  function automatic logic [15:0] ref_hash(logic [63:0] a);
    logic [15:0] x;
    x = a[15:0] ^ a[31:16] ^ a[47:32] ^ a[63:48];
    x ^= 16'(x << 5);
    x ^= 16'(x >> 7);
    x ^= 16'(x << 3);
    return x;
  endfunction

  function automatic logic [15:0] model_sig();
    logic [15:0] s;
    for (int i = 0; i < 16; i++) s[i] = (cntm[i] != 0);
    return s;
  endfunction

  task automatic model_push(logic [63:0] a);
    logic [15:0] h, o;
    h = ref_hash(a);
    if (hq.size() == 32) begin
      o = hq.pop_front();
      for (int i = 0; i < 16; i++) if (o[i]) cntm[i]--;
    end
    hq.push_back(h);
    for (int i = 0; i < 16; i++) if (h[i]) cntm[i]++;
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check registered response after rising edge
  task automatic step(bit pv, logic [63:0] a, bit qv, logic [15:0] ctx, logic [7:0] tag, string req);
    bit exp_fire;
    @(negedge clk_i);
    push_valid_i  = pv;
    push_addr_i   = a;
    query_valid_i = qv;
    query_ctx_i   = ctx;
    query_tag_i   = tag;
    exp_fire = ((ctx & ~model_sig()) == 16'h0);
    @(posedge clk_i);
    #1;
    check(resp_valid_o == qv, "R2", 32'(resp_valid_o), 32'(qv));
    if (qv) begin
      check(resp_tag_o == tag, "R2", 32'(resp_tag_o), 32'(tag));
      check(resp_fire_o == exp_fire, req, 32'(resp_fire_o), 32'(exp_fire));
    end
    if (pv) model_push(a);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a0, a;
    logic [15:0] s, c;
    int unsigned r;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 16; i++) cntm[i] = 0;
    #23 rst_ni = 1'b1;
    #1;
    check(resp_valid_o == 1'b0, "R1", 32'(resp_valid_o), 32'd0);

    // R1 empty signature suppresses full context; R8 zero context fires
    step(0, '0, 1, 16'hFFFF, 8'h01, "R1");
    step(0, '0, 1, 16'h0000, 8'h02, "R8");

    // R7 query with push in same cycle sees pre-push signature
    a0 = 64'h0000_7F3A_1200_4C80;
    step(1, a0, 1, ref_hash(a0), 8'h03, "R7");
    // R4 pushed hash now present
    step(0, '0, 1, ref_hash(a0), 8'h04, "R4");
    step(0, '0, 1, ref_hash(a0) | ~model_sig(), 8'h05, "R3");

    // R6 fill to 32, first entry still present
    for (int k = 1; k < 32; k++) step(1, 64'h1000 + 64'(k) * 64'h9E37, 0, '0, '0, "R6");
    step(0, '0, 1, ref_hash(a0), 8'h06, "R6");

    // R5 33rd push evicts first; probe bits unique to first entry
    step(1, 64'h5555_0000_AAAA_0001, 0, '0, '0, "R5");
    s = model_sig();
    c = ref_hash(a0) & ~s;
    step(0, '0, 1, (c != 0) ? c : ref_hash(a0), 8'h07, "R5");
    step(0, '0, 1, s, 8'h08, "R5");

    // R9 same address repeatedly: push and evict cancel, bits stay present
    a = 64'hDEAD_BEEF_0BAD_F00D;
    for (int k = 0; k < 40; k++) step(1, a, (k % 4) == 3, ref_hash(a), 8'(k), "R9");
    step(0, '0, 1, ref_hash(a), 8'h09, "R9");

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      r = $urandom();
      s = model_sig();
      case (r[3:2])
        2'd0: c = 16'($urandom()) & s;
        2'd1: c = 16'($urandom());
        2'd2: c = (hq.size() > 0) ? hq[$urandom_range(hq.size()-1)] : 16'h0;
        default: c = (16'($urandom()) & s) | (16'h1 << r[7:4]);
      endcase
      a = {48'h0, 16'($urandom_range(200))} ^ {32'($urandom()), 32'h0};
      step(r[0], a, r[1] | r[8], c, 8'($urandom()), "R3");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule